// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes a single PWM waveform and distributes it over four output pins, called A, B, C and D here (pin indices 0 to 3). A control register chooses either an arbitrary subset of pins that each carry the waveform, or a complementary pair made of pin A and one partner pin. Any pin that does not carry the waveform drives a general-purpose port value instead. Polarity is applied per pin from a two-bit select input.

Register writes land first in a shadow copy. The sync bit of the written value decides when the shadow reaches the active configuration that drives the pins. With sync clear it lands at the write edge. With sync set it waits for the edge on which the period-start strobe is high, so a pulse already in progress is never cut short. Steering applies only while the enclosing PWM unit reports single-output PWM mode. Otherwise all four pins fall back to their port values.

Top module: `pwm_steer`

## Requirements
- R1: After reset the register reads 0x01: pin A is steered, all other control bits are zero. With steering allowed, pin A carries the waveform and pins B to D carry their port values.
- R2: A register read returns the last value written, with bit 5 always read as 0. The layout is: bits 7:6 pairing code, bit 5 unused, bit 4 sync, bit 3 to bit 0 steering enables for D, C, B, A.
- R3: With pairing code 00, pin i carries the waveform and raises `pin_steer[i]` when enable bit i is 1. When the bit is 0, pin i drives `port_val[i]` and `pin_steer[i]` is 0.
- R4: A steered pin carries `pwm_in` XOR an invert bit. The invert bit is `pol_sel[1]` for pins A and C (even index) and `pol_sel[0]` for pins B and D (odd index).
- R5: A nonzero pairing code k (01 = B, 10 = C, 11 = D) steers pin A with its polarity-adjusted waveform and drives pin k with the logical inverse of pin A. The other two pins drive port values, and `pin_steer` has exactly bits 0 and k set.
- R6: A write with sync 0 changes the pins from the clock edge that accepts it. Before that edge the pins still follow the previous configuration.
- R7: A write with sync 1 leaves the pins on the previous configuration until a clock edge at which `period_start` is high. From that edge on, the written configuration applies. A sync-1 write accepted on an edge with `period_start` high applies at once.
- R8: While `pwm_mode_ok` is 0, every pin drives its port value and `pin_steer` is 0, whatever the register holds. Writes are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value (shadow copy) |
| period_start | input | 1 | Strobe marking the first cycle of a PWM period |
| pwm_mode_ok | input | 1 | High when the PWM unit is in single-output PWM mode |
| pwm_in | input | 1 | Raw PWM waveform |
| pol_sel | input | 2 | Polarity select: bit 1 inverts pins A/C, bit 0 inverts pins B/D |
| port_val | input | 4 | Port values for unsteered pins |
| pin_out | output | 4 | Pin drive values, bit 0 = pin A |
| pin_steer | output | 4 | High for each pin that carries the waveform |

## Verification
The bench builds the block with its default of four pins, which gives an eight-bit register and a two-bit pairing code. At this size every register value can be written and checked. For each value the bench applies all four polarity codes, both waveform levels and two complementary port patterns, and compares the pins with a model computed in the bench. Separate sequences make sync-set changes in the middle of a period and confirm they stay off the pins until the period-start edge. They also cover a sync write that coincides with the strobe and an immediate write seen just before and after its edge.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    // Invert bit for pin idx: even pins follow pol[1], odd pins follow pol[0].
    function automatic logic pin_invert(input logic [1:0] pol, input int unsigned idx);
        return (idx % 2 == 1) ? pol[0] : pol[1];
    endfunction

    // Reset value of the control register: pin A steered, all else zero.
    localparam logic [7:0] CFG_RESET = 8'h01;

endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs #(
    parameter int unsigned PINS = 4,
    localparam int unsigned CW = $clog2(PINS),
    localparam int unsigned RW = PINS + 2 + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    input  logic          period_start,
    output logic [RW-1:0] shadow_cfg,
    output logic [RW-1:0] act_cfg
);
    import pwm_steer_pkg::*;

    localparam int unsigned SYNC_BIT = PINS;
    localparam int unsigned GAP_BIT  = PINS + 1;
    localparam logic [RW-1:0] KEEP_MASK = ~(RW'(1) << GAP_BIT);
    localparam logic [RW-1:0] RST_VAL  = RW'(CFG_RESET);

    typedef struct packed {
        logic [RW-1:0] shadow;
        logic [RW-1:0] active;
    } regs_t;

    regs_t         st_d, st_q;
    logic [RW-1:0] wval;

    always_comb begin
        st_d = st_q;
        wval = wr_data & KEEP_MASK;
        if (wr_en) begin
            st_d.shadow = wval;
            if (!wval[SYNC_BIT] || period_start) begin
                st_d.active = wval;
            end
        end else if (period_start && st_q.shadow[SYNC_BIT]) begin
            st_d.active = st_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shadow <= RST_VAL;
            st_q.active <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_cfg = st_q.shadow;
    assign act_cfg    = st_q.active;

endmodule

// File: rtl/pwm_steer_pin.sv
module pwm_steer_pin #(
    parameter int unsigned PINS = 4,
    parameter int unsigned IDX  = 0,
    localparam int unsigned CW = $clog2(PINS)
) (
    input  logic          mode_ok,
    input  logic          pwm_in,
    input  logic          pwm_a,
    input  logic [1:0]    pol_sel,
    input  logic          steer_en,
    input  logic [CW-1:0] pair_code,
    input  logic          port_bit,
    output logic          drive,
    output logic          steered
);
    import pwm_steer_pkg::*;

    localparam logic [CW-1:0] MY_CODE = CW'(IDX);

    logic own_wave;

    always_comb begin
        own_wave = pwm_in ^ pin_invert(pol_sel, IDX);
        drive    = port_bit;
        steered  = 1'b0;
        if (mode_ok) begin
            if (pair_code == '0) begin
                steered = steer_en;
                drive   = steer_en ? own_wave : port_bit;
            end else if (IDX == 0) begin
                steered = 1'b1;
                drive   = own_wave;
            end else if (pair_code == MY_CODE) begin
                steered = 1'b1;
                drive   = ~pwm_a;
            end
        end
    end

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
    parameter int unsigned PINS = 4,
    localparam int unsigned CW = $clog2(PINS),
    localparam int unsigned RW = PINS + 2 + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_data,
    output logic [RW-1:0]   rd_data,
    input  logic            period_start,
    input  logic            pwm_mode_ok,
    input  logic            pwm_in,
    input  logic [1:0]      pol_sel,
    input  logic [PINS-1:0] port_val,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_steer
);
    import pwm_steer_pkg::*;

    logic [RW-1:0]   shadow_cfg;
    logic [RW-1:0]   act_cfg;
    logic [PINS-1:0] act_steer;
    logic [CW-1:0]   act_pair;
    logic            pwm_a;

    pwm_steer_regs #(.PINS(PINS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .period_start (period_start),
        .shadow_cfg   (shadow_cfg),
        .act_cfg      (act_cfg)
    );

    assign rd_data   = shadow_cfg;
    assign act_steer = act_cfg[PINS-1:0];
    assign act_pair  = act_cfg[RW-1 -: CW];
    assign pwm_a     = pwm_in ^ pin_invert(pol_sel, 0);

    for (genvar gi = 0; gi < PINS; gi++) begin : g_pin
        pwm_steer_pin #(.PINS(PINS), .IDX(gi)) u_pin (
            .mode_ok   (pwm_mode_ok),
            .pwm_in    (pwm_in),
            .pwm_a     (pwm_a),
            .pol_sel   (pol_sel),
            .steer_en  (act_steer[gi]),
            .pair_code (act_pair),
            .port_bit  (port_val[gi]),
            .drive     (pin_out[gi]),
            .steered   (pin_steer[gi])
        );
    end

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
    parameter int unsigned PINS = 4,
    localparam int unsigned CW = $clog2(PINS),
    localparam int unsigned RW = PINS + 2 + CW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [RW-1:0]   wr_data,
    input logic [RW-1:0]   rd_data,
    input logic            period_start,
    input logic            pwm_mode_ok,
    input logic [PINS-1:0] port_val,
    input logic [PINS-1:0] pin_out,
    input logic [PINS-1:0] pin_steer,
    input logic [RW-1:0]   act_cfg
);
    localparam int unsigned SYNC_BIT = PINS;
    localparam int unsigned GAP_BIT  = PINS + 1;
    localparam logic [RW-1:0] KEEP_MASK = ~(RW'(1) << GAP_BIT);

    logic [CW-1:0] pair_now;
    assign pair_now = act_cfg[RW-1 -: CW];

    AST_GAP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[GAP_BIT] == 1'b0); // R2

    AST_INDIVIDUAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_ok && pair_now == '0) |-> pin_steer == act_cfg[PINS-1:0]); // R3

    AST_PAIR_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_ok && pair_now != '0) |-> (pin_out[pair_now] == ~pin_out[0]
            && $countones(pin_steer) == 2)); // R5

    AST_IMMEDIATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[SYNC_BIT]) |=> act_cfg == ($past(wr_data) & KEEP_MASK)); // R6

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && !(wr_en && !wr_data[SYNC_BIT])) |=> $stable(act_cfg)); // R7

    AST_MODE_OFF_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_mode_ok |-> (pin_steer == '0 && pin_out == port_val)); // R8

endmodule

bind pwm_steer pwm_steer_chk #(.PINS(PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .period_start (period_start),
    .pwm_mode_ok  (pwm_mode_ok),
    .port_val     (port_val),
    .pin_out      (pin_out),
    .pin_steer    (pin_steer),
    .act_cfg      (act_cfg)
);

// File: tb/pwm_steer_bench.sv
`timescale 1ns/1ps
module pwm_steer_bench;
    localparam int PINS = 4;
    localparam int RW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [RW-1:0]   wr_data = '0;
    logic [RW-1:0]   rd_data;
    logic            period_start = 1'b0;
    logic            pwm_mode_ok = 1'b1;
    logic            pwm_in = 1'b0;
    logic [1:0]      pol_sel = 2'b00;
    logic [PINS-1:0] port_val = '0;
    logic [PINS-1:0] pin_out;
    logic [PINS-1:0] pin_steer;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_steer #(.PINS(PINS)) u_pwm_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .period_start (period_start),
        .pwm_mode_ok  (pwm_mode_ok),
        .pwm_in       (pwm_in),
        .pol_sel      (pol_sel),
        .port_val     (port_val),
        .pin_out      (pin_out),
        .pin_steer    (pin_steer)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {pin_steer, pin_out} from the requirements.
    function automatic logic [7:0] model(input logic [7:0] cfg, input logic mode,
                                         input logic pwm, input logic [1:0] pol,
                                         input logic [3:0] port);
        logic [3:0] st, o;
        int cm;
        cm = int'(cfg[7:6]);
        st = 4'b0000;
        o  = port;
        if (mode) begin
            if (cm == 0) begin
                st = cfg[3:0];
                for (int i = 0; i < 4; i++)
                    if (st[i]) o[i] = pwm ^ ((i % 2 == 1) ? pol[0] : pol[1]);
            end else begin
                st = 4'b0001 | (4'b0001 << cm);
                o[0]  = pwm ^ pol[1];
                o[cm] = ~o[0];
            end
        end
        return {st, o};
    endfunction

    // Sweep polarity, waveform level and port pattern within one low phase.
    task automatic pin_sweep(input string req, input logic [7:0] cfg);
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 2; w++) begin
                for (int q = 0; q < 2; q++) begin
                    pol_sel  = 2'(p);
                    pwm_in   = w[0];
                    port_val = q[0] ? 4'b1010 : 4'b0101;
                    #0.1;
                    check(req, {pin_steer, pin_out},
                          model(cfg, pwm_mode_ok, pwm_in, pol_sel, port_val));
                end
            end
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        // R1: reset state
        check("R1", rd_data, 8'h01);
        pin_sweep("R1", 8'h01);

        // R2 R3 R4 R5: every register value with sync clear
        for (int c = 0; c < 256; c++) begin
            d = 8'(c) & 8'hEF;
            write_reg(d);
            #0.1;
            check("R2", rd_data, d & 8'hDF);
            pin_sweep((d[7:6] == 2'b00) ? "R3/R4" : "R5", d);
        end

        // R6: immediate write not visible before its edge, visible after
        write_reg(8'h01);
        pol_sel = 2'b00; pwm_in = 1'b1; port_val = 4'b0000;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h0C;
        #0.1;
        check("R6", {pin_steer, pin_out}, model(8'h01, 1'b1, 1'b1, 2'b00, 4'b0000));
        @(negedge clk);
        wr_en = 1'b0;
        #0.1;
        check("R6", {pin_steer, pin_out}, model(8'h0C, 1'b1, 1'b1, 2'b00, 4'b0000));

        // R7: sync write mid-period stays off the pins until period start
        write_reg(8'h01);
        write_reg(8'h1C);
        #0.1;
        check("R2", rd_data, 8'h1C);
        for (int k = 0; k < 3; k++) begin
            pin_sweep("R7 hold", 8'h01);
            @(negedge clk);
        end
        period_start = 1'b1;
        pin_sweep("R7 before edge", 8'h01);
        @(negedge clk);
        period_start = 1'b0;
        pin_sweep("R7 after edge", 8'h1C);

        // R7: sync change of the pairing code
        write_reg(8'hD0);
        pin_sweep("R7 hold pair", 8'h1C);
        @(negedge clk);
        pin_sweep("R7 hold pair", 8'h1C);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        pin_sweep("R7 pair applied", 8'hD0);

        // R7: sync write on a period-start edge applies at once
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h93; period_start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; period_start = 1'b0;
        pin_sweep("R7 same edge", 8'h93);

        // R6: a sync-0 write after sync mode applies immediately
        write_reg(8'h05);
        pin_sweep("R6", 8'h05);

        // R8: steering disabled outside single-output PWM mode
        pwm_mode_ok = 1'b0;
        pin_sweep("R8", 8'h05);
        write_reg(8'h6F);
        #0.1;
        check("R8", rd_data, 8'h4F);
        pin_sweep("R8", 8'h4F);
        pwm_mode_ok = 1'b1;
        pin_sweep("R8 restored", 8'h4F);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule